// File: doc/BRIEF.md
# 14-bit Down-Counter Timer

This block is a programmable 14-bit timer for a peripheral controller. The count length and an output shape are loaded through two byte-wide registers, and a two-bit command field in the peripheral command register starts, stops or retargets the counter. The counter steps down once per rising edge of a separate timer clock input. That input is synchronised into the bus clock domain, so the timer clock only needs to be slower than half the bus clock. The block drives one timer output pin and raises a sticky terminal-count flag for the status logic.

The surrounding bus logic decodes addresses and hands the block one-cycle write strobes, a shared write-data byte and a status-read strobe. All of these are plain control pins without valid/ready handshaking. A write strobe is taken in the cycle it is high, and the block never applies back-pressure. Writing a length or a shape has no effect on a running count until a start or reload command is given.

Top module: `tmr14_top`

## Requirements
- R1: While `rst_n` is low and after it is released, the counter is stopped, `tmr_out_o` is high and `tc_flag_o` is low.
- R2: A `lo_wr_i` strobe stores `wdata_i[7:0]` as count bits 7..0. A `hi_wr_i` strobe stores `wdata_i[5:0]` as count bits 13..8 and `wdata_i[7:6]` as the output shape: 00 one low half-period, 01 repeating square wave, 10 one terminal-count pulse, 11 repeating pulses. A `cmd_wr_i` strobe takes the command from `wdata_i[7:6]`.
- R3: While running, the count drops by one on each rising edge of `tmr_clk_i`. Terminal count is the edge that finds the count at 1, so a length L gives a period of L timer edges. A stored length of 0 or 1 is used as 2.
- R4: In the two square shapes, the output is high for the first ceil(L/2) timer periods of each count and low for the remaining floor(L/2).
- R5: In the two pulse shapes, the output is high while counting and goes low for exactly one timer period after each terminal count.
- R6: In the one-shot shapes (00 and 10), the counter stops at terminal count. Further timer edges then raise no flag, and the output stays high once the shape's low phase has ended.
- R7: In the repeating shapes (01 and 11), the counter reloads its length at terminal count and continues without a gap.
- R8: Each terminal count sets `tc_flag_o`. The flag stays set across timer edges until a `stat_rd_i` strobe clears it. A terminal count in the same cycle as a read wins.
- R9: Command 00 has no effect on a running or stopped counter.
- R10: Command 01 stops a running counter at the next bus clock edge and drives the output high.
- R11: Command 10 lets a running counter finish its current count, then stops it at terminal count.
- R12: Command 11 starts a stopped counter with the stored length and shape. On a running counter, it does not restart the count. Instead, the stored length and shape take over at the next terminal count. Register writes alone never alter a running count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_clk_i | input | 1 | Timer clock, counted on rising edges after synchronisation |
| lo_wr_i | input | 1 | Write strobe for the low count byte |
| hi_wr_i | input | 1 | Write strobe for the high count bits and output shape |
| cmd_wr_i | input | 1 | Write strobe for the command field |
| wdata_i | input | 8 | Write data shared by the three strobes |
| stat_rd_i | input | 1 | Status read strobe, clears the terminal-count flag |
| tmr_out_o | output | 1 | Timer output pin |
| tc_flag_o | output | 1 | Sticky terminal-count flag |

## Verification
Register writes, commands and status reads take effect at the first bus clock edge after their strobe, so their results are sampled on the next falling edge. A rising edge on `tmr_clk_i` passes two synchroniser stages before it updates the counter, output and flag on the third bus clock edge. The bench therefore holds each timer clock level for three bus cycles and samples only after the level has settled. Each shape's high and low run lengths are counted tick by tick against values worked out from the length.

// File: rtl/tmr14_pkg.sv
package tmr14_pkg;

  typedef enum logic [1:0] {
    CMD_NOP     = 2'b00,
    CMD_HALT    = 2'b01,
    CMD_HALT_TC = 2'b10,
    CMD_GO      = 2'b11
  } tmr_cmd_e;

  // bit 0: repeat after terminal count, bit 1: pulse shape instead of square
  typedef enum logic [1:0] {
    SHAPE_HALF_ONCE  = 2'b00,
    SHAPE_SQUARE     = 2'b01,
    SHAPE_PULSE_ONCE = 2'b10,
    SHAPE_PULSE_RUN  = 2'b11
  } tmr_shape_e;

endpackage

// File: rtl/tmr14_tick_sync.sv
module tmr14_tick_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tmr_clk_i,
  output logic tick_o
);
  localparam int LAST = SYNC_STAGES;

  logic [LAST:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[LAST-1:0], tmr_clk_i};
  end

  // rising edge seen once it has crossed the synchroniser stages
  assign tick_o = sh_q[LAST-1] & ~sh_q[LAST];
endmodule

// File: rtl/tmr14_regs.sv
module tmr14_regs #(
  parameter int CW = 14,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lo_wr_i,
  input  logic          hi_wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [CW-1:0] len_o,
  output logic [1:0]    shape_o
);
  localparam int HW = CW - DW;

  logic [DW-1:0] lo_q;
  logic [HW-1:0] hi_q;
  logic [1:0]    shape_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q    <= '0;
      hi_q    <= '0;
      shape_q <= 2'b00;
    end else begin
      if (lo_wr_i) lo_q <= wdata_i;
      if (hi_wr_i) begin
        hi_q    <= wdata_i[HW-1:0];
        shape_q <= wdata_i[DW-1 -: 2];
      end
    end
  end

  assign len_o   = {hi_q, lo_q};
  assign shape_o = shape_q;
endmodule

// File: rtl/tmr14_counter.sv
module tmr14_counter
  import tmr14_pkg::*;
#(
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          cmd_wr_i,
  input  logic [1:0]    cmd_i,
  input  logic [CW-1:0] len_i,
  input  logic [1:0]    shape_i,
  output logic          run_o,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] act_len_o,
  output logic [1:0]    act_shape_o,
  output logic          tc_o,
  output logic          halt_o
);
  localparam logic [CW-1:0] MIN_LEN = CW'(2);
  localparam logic [CW-1:0] ONE     = CW'(1);

  function automatic logic [CW-1:0] eff_len(input logic [CW-1:0] v);
    return (v < MIN_LEN) ? MIN_LEN : v;
  endfunction

  tmr_cmd_e cmd;
  assign cmd = tmr_cmd_e'(cmd_i);

  logic          run_q, run_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] alen_q, alen_d;
  logic [1:0]    ashape_q, ashape_d;
  logic          stop_q, stop_d;
  logic          rel_q, rel_d;
  logic [CW-1:0] new_len;

  assign new_len = eff_len(len_i);
  assign tc_o    = tick_i && run_q && (cnt_q == ONE);
  assign halt_o  = cmd_wr_i && (cmd == CMD_HALT);

  always_comb begin
    run_d    = run_q;
    cnt_d    = cnt_q;
    alen_d   = alen_q;
    ashape_d = ashape_q;
    stop_d   = stop_q;
    rel_d    = rel_q;

    if (tick_i && run_q) begin
      if (cnt_q == ONE) begin
        if (stop_q || !ashape_q[0]) begin
          run_d  = 1'b0;
          stop_d = 1'b0;
          rel_d  = 1'b0;
        end else if (rel_q) begin
          cnt_d    = new_len;
          alen_d   = new_len;
          ashape_d = shape_i;
          rel_d    = 1'b0;
        end else begin
          cnt_d = alen_q;
        end
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end

    if (cmd_wr_i) begin
      unique case (cmd)
        CMD_HALT: begin
          run_d  = 1'b0;
          stop_d = 1'b0;
          rel_d  = 1'b0;
        end
        CMD_HALT_TC: begin
          if (run_q) stop_d = 1'b1;
        end
        CMD_GO: begin
          if (!run_q) begin
            run_d    = 1'b1;
            cnt_d    = new_len;
            alen_d   = new_len;
            ashape_d = shape_i;
            stop_d   = 1'b0;
            rel_d    = 1'b0;
          end else begin
            rel_d = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      cnt_q    <= MIN_LEN;
      alen_q   <= MIN_LEN;
      ashape_q <= SHAPE_HALF_ONCE;
      stop_q   <= 1'b0;
      rel_q    <= 1'b0;
    end else begin
      run_q    <= run_d;
      cnt_q    <= cnt_d;
      alen_q   <= alen_d;
      ashape_q <= ashape_d;
      stop_q   <= stop_d;
      rel_q    <= rel_d;
    end
  end

  assign run_o       = run_q;
  assign cnt_o       = cnt_q;
  assign act_len_o   = alen_q;
  assign act_shape_o = ashape_q;
endmodule

// File: rtl/tmr14_wave.sv
module tmr14_wave #(
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          tc_i,
  input  logic          halt_i,
  input  logic          run_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] act_len_i,
  input  logic [1:0]    act_shape_i,
  output logic          out_o
);
  logic          pulse_q;
  logic [CW-1:0] half;
  logic          sq_low;

  always_ff @(posedge clk) begin
    if (!rst_n)                     pulse_q <= 1'b0;
    else if (halt_i)                pulse_q <= 1'b0;
    else if (tc_i && act_shape_i[1]) pulse_q <= 1'b1;
    else if (tick_i)                pulse_q <= 1'b0;
  end

  assign half   = act_len_i >> 1;
  assign sq_low = run_i && (cnt_i <= half);
  assign out_o  = act_shape_i[1] ? ~pulse_q : ~sq_low;
endmodule

// File: rtl/tmr14_top.sv
module tmr14_top #(
  parameter int CNT_W       = 14,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_clk_i,
  input  logic              lo_wr_i,
  input  logic              hi_wr_i,
  input  logic              cmd_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              stat_rd_i,
  output logic              tmr_out_o,
  output logic              tc_flag_o
);
  localparam int CMD_MSB = DATA_W - 1;

  logic             tick_w;
  logic [CNT_W-1:0] len_w;
  logic [1:0]       shape_w;
  logic             run_w;
  logic [CNT_W-1:0] cnt_w;
  logic [CNT_W-1:0] alen_w;
  logic [1:0]       ashape_w;
  logic             tc_w;
  logic             halt_w;
  logic             flag_q;

  tmr14_tick_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .tmr_clk_i(tmr_clk_i), .tick_o(tick_w)
  );

  tmr14_regs #(.CW(CNT_W), .DW(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .lo_wr_i(lo_wr_i), .hi_wr_i(hi_wr_i),
    .wdata_i(wdata_i), .len_o(len_w), .shape_o(shape_w)
  );

  tmr14_counter #(.CW(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_w), .cmd_wr_i(cmd_wr_i),
    .cmd_i(wdata_i[CMD_MSB -: 2]), .len_i(len_w), .shape_i(shape_w),
    .run_o(run_w), .cnt_o(cnt_w), .act_len_o(alen_w), .act_shape_o(ashape_w),
    .tc_o(tc_w), .halt_o(halt_w)
  );

  tmr14_wave #(.CW(CNT_W)) u_wave (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_w), .tc_i(tc_w), .halt_i(halt_w),
    .run_i(run_w), .cnt_i(cnt_w), .act_len_i(alen_w), .act_shape_i(ashape_w),
    .out_o(tmr_out_o)
  );

  // sticky terminal-count flag, a new terminal count beats a read
  always_ff @(posedge clk) begin
    if (!rst_n)         flag_q <= 1'b0;
    else if (tc_w)      flag_q <= 1'b1;
    else if (stat_rd_i) flag_q <= 1'b0;
  end

  assign tc_flag_o = flag_q;
endmodule

// File: rtl/tmr14_chk.sv
module tmr14_chk #(
  parameter int CW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          tc,
  input logic          run,
  input logic [CW-1:0] cnt,
  input logic [1:0]    act_shape,
  input logic          cmd_wr,
  input logic [1:0]    cmd,
  input logic          stat_rd,
  input logic          flag,
  input logic          tmr_out
);
  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> flag);

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !tc) |=> !flag);

  // R10
  halt_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd == 2'b01) |=> (!run && tmr_out));

  // R3
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick && !cmd_wr) |=> $stable(cnt));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && cnt > CW'(1) && !cmd_wr) |=> (cnt == $past(cnt) - CW'(1)));

  // R6
  single_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && !act_shape[0] && !cmd_wr) |=> !run);

  // R3
  count_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt != '0));
endmodule

bind tmr14_top tmr14_chk #(.CW(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick_w), .tc(tc_w), .run(run_w),
  .cnt(cnt_w), .act_shape(ashape_w), .cmd_wr(cmd_wr_i),
  .cmd(wdata_i[DATA_W-1 -: 2]), .stat_rd(stat_rd_i), .flag(tc_flag_o),
  .tmr_out(tmr_out_o)
);

// File: tb/tb_tmr14_top.sv
module tb_tmr14_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tclk = 1'b0;
  logic       lo_wr = 1'b0, hi_wr = 1'b0, cmd_wr = 1'b0, stat_rd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       tout, flag;
  int         total = 0, fails = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  tmr14_top dut (
    .clk(clk), .rst_n(rst_n), .tmr_clk_i(tclk), .lo_wr_i(lo_wr), .hi_wr_i(hi_wr),
    .cmd_wr_i(cmd_wr), .wdata_i(wdata), .stat_rd_i(stat_rd),
    .tmr_out_o(tout), .tc_flag_o(flag)
  );

  typedef struct packed {
    logic [13:0] len;
    logic [1:0]  shape;
    logic [15:0] per;
    logic [15:0] hi;
    logic [15:0] lo;
    logic        tc_out;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{14'd6,   2'd1, 16'd6,   16'd3,   16'd3, 1'b1},
    '{14'd7,   2'd1, 16'd7,   16'd4,   16'd3, 1'b1},
    '{14'd5,   2'd0, 16'd5,   16'd3,   16'd2, 1'b1},
    '{14'd4,   2'd2, 16'd4,   16'd4,   16'd0, 1'b0},
    '{14'd300, 2'd3, 16'd300, 16'd300, 16'd0, 1'b0},
    '{14'd1,   2'd1, 16'd2,   16'd1,   16'd1, 1'b1}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int which, input logic [7:0] d);
    @(negedge clk);
    wdata = d;
    if (which == 0) lo_wr = 1'b1;
    else if (which == 1) hi_wr = 1'b1;
    else cmd_wr = 1'b1;
    @(negedge clk);
    lo_wr = 1'b0; hi_wr = 1'b0; cmd_wr = 1'b0;
  endtask

  task automatic cmd(input logic [1:0] c);
    wr(2, {c, 6'b0});
  endtask

  task automatic rd_stat();
    @(negedge clk);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tclk = 1'b1;
      repeat (3) @(negedge clk);
      tclk = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic start(input logic [13:0] len, input logic [1:0] shape);
    cmd(2'b01);
    rd_stat();
    wr(0, len[7:0]);
    wr(1, {shape, len[13:8]});
    cmd(2'b11);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1", "out in reset", tout, 1);
    chk("R1", "flag in reset", flag, 0);
    rst_n = 1'b1;
    @(negedge clk);
    ticks(3);
    chk("R1", "out after reset", tout, 1);
    chk("R1", "flag after reset", flag, 0);

    // table walk: R2 R3 R4 R5 R6 R7 R8
    for (int v = 0; v < 6; v++) begin
      int nh, nl;
      nh = 0; nl = 0;
      start(VEC[v].len, VEC[v].shape);
      for (int k = 0; k < int'(VEC[v].per); k++) begin
        if (tout) nh++; else nl++;
        ticks(1);
      end
      chk("R4/R5", $sformatf("vec %0d high run", v), nh, int'(VEC[v].hi));
      chk("R4/R5", $sformatf("vec %0d low run", v), nl, int'(VEC[v].lo));
      chk("R3", $sformatf("vec %0d out at terminal count", v), tout, int'(VEC[v].tc_out));
      chk("R8", $sformatf("vec %0d flag at terminal count", v), flag, 1);
    end

    // R5 R7 R8: repeating pulses, length 3
    start(14'd3, 2'd3);
    ticks(3);
    chk("R5", "pulse low after tc", tout, 0);
    chk("R8", "flag set", flag, 1);
    rd_stat();
    chk("R8", "flag cleared by read", flag, 0);
    ticks(1);
    chk("R5", "pulse ends after one period", tout, 1);
    ticks(2);
    chk("R7", "second terminal count flag", flag, 1);
    chk("R7", "second pulse low", tout, 0);
    ticks(2);
    chk("R8", "flag sticky across ticks", flag, 1);

    // R6: one-shot half stops
    start(14'd4, 2'd0);
    ticks(4);
    chk("R6", "one-shot flag", flag, 1);
    rd_stat();
    ticks(6);
    chk("R6", "no flag after stop", flag, 0);
    chk("R6", "out high after stop", tout, 1);

    // R10: immediate stop
    start(14'd8, 2'd1);
    ticks(5);
    chk("R10", "low phase before stop", tout, 0);
    cmd(2'b01);
    chk("R10", "out high after stop", tout, 1);
    ticks(10);
    chk("R10", "no flag after stop", flag, 0);

    // R11: stop after terminal count
    start(14'd4, 2'd1);
    ticks(1);
    cmd(2'b10);
    ticks(2);
    chk("R11", "still counting low", tout, 0);
    chk("R11", "no flag before tc", flag, 0);
    ticks(1);
    chk("R11", "flag at tc", flag, 1);
    chk("R11", "out high at tc", tout, 1);
    rd_stat();
    ticks(3);
    chk("R11", "stopped out high", tout, 1);
    chk("R11", "stopped no flag", flag, 0);

    // R9: command 00
    start(14'd6, 2'd1);
    ticks(2);
    cmd(2'b00);
    ticks(1);
    chk("R9", "low phase kept", tout, 0);
    ticks(3);
    chk("R9", "period unchanged", flag, 1);

    // R12: register writes alone and reload at tc
    start(14'd4, 2'd1);
    ticks(1);
    wr(0, 8'd10);
    ticks(3);
    chk("R12", "write alone keeps period", flag, 1);
    rd_stat();
    ticks(1);
    cmd(2'b11);
    ticks(3);
    chk("R12", "go while running no restart", flag, 1);
    rd_stat();
    ticks(4);
    chk("R12", "new length high phase", tout, 1);
    chk("R12", "new length no early tc", flag, 0);
    ticks(1);
    chk("R12", "new length low phase", tout, 0);

    // R1: reset during a run
    start(14'd6, 2'd1);
    ticks(4);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "mid-run reset out", tout, 1);
    chk("R1", "mid-run reset flag", flag, 0);
    rst_n = 1'b1;
    ticks(8);
    chk("R1", "stays stopped after reset", flag, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule